// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of an asynchronous byte-wide flash device. It turns one request into the full bus conversation that the device expects. The request can program a single byte, erase the whole array, or erase a set of sectors. The block drives chip enable, write enable and output enable, generates the unlock and command write cycles, and then reads status at a chosen address. It repeats that read until the device reports completion or a time-limit fault.

A request is presented with `req_valid` while `idle` is high. It carries an operation code, a target address, a data byte and a sector mask. When the work is over, `done` pulses for one cycle and `pass` gives the verdict. Pulse width, setup, hold and read-access times are parameters counted in clock cycles. The data bus is split into a driven output with an enable and a separate input, so the pad ring can build the tristate.

Top module: `flash_prog_ctrl`

## Requirements
- R1: While reset is held and right after it, chip enable, write enable and output enable are all high, `done` is low and `idle` is high.
- R2: Operation code 0 (program) issues exactly four writes, in this order: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then the request address with the request byte.
- R3: Operation code 1 (chip erase) issues exactly six writes, in this order: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, 5555h/10h.
- R4: Operation code 2 (sector erase) issues the first five writes of R3. It then issues one 30h write for each set bit of the sector mask, in ascending bit order. Each of these goes to the address whose top log2(NSEC) bits hold the bit index and whose other bits are zero.
- R5: In every write cycle, write enable is low for exactly T_PULSE cycles, and chip enable stays low from before write enable falls until after it rises. Address and output data stay constant while chip enable is low. Write enable and output enable are never low together.
- R6: After the command writes, the block reads status with chip enable and output enable low. Each read goes to the poll address: the request address for a program, 0 for chip erase, and the base of the lowest selected sector for sector erase. The block keeps reading until a verdict is reached.
- R7: A status byte whose bit 7 equals the expected value ends the operation with `pass`=1. The expected value is bit 7 of the written byte for a program, and 1 for an erase. This holds even when bit 5 of that same byte is set.
- R8: A status byte that has no bit 7 match but has bit 5 set causes exactly one further read. If that read matches, the result is pass. Otherwise the block writes F0h to address 0 and then reports `pass`=0.
- R9: `done` is high for exactly one cycle per accepted request. While `idle` is low, `req_valid` is ignored and starts no further bus cycles.
- R10: Operation code 3, or operation code 2 with an all-zero sector mask, finishes with `pass`=0 and performs no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle is high |
| req_op | input | 2 | 0 program, 1 chip erase, 2 sector erase, 3 rejected |
| req_addr | input | AW | Byte address for a program |
| req_data | input | 8 | Byte to program |
| req_sec_mask | input | NSEC | Sectors to erase, bit i selects sector i |
| idle | output | 1 | Ready for a request |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid while done is high |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | 8 | Data driven onto the flash bus |
| fl_doe | output | 1 | Output enable for the data pads |
| fl_din | input | 8 | Data read from the flash bus |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
Two conditions can arrive in the same status byte: a bit 7 match and the bit 5 time-limit flag. The bench's flash model has a mode that returns the final data with bit 5 forced high. The block must report pass after a single read and must not issue the reset write. The other collision is a new request that arrives while an operation is still in flight. The bench strobes a chip erase partway through a program. It then checks that only the program's four writes appear on the bus, both before and well after `done`.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_CHIP = 2'd1,
    OP_SECT = 2'd2,
    OP_BAD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    V_RETRY = 2'd0,
    V_LATE  = 2'd1,
    V_PASS  = 2'd2,
    V_FAIL  = 2'd3
  } verdict_e;

  localparam logic [15:0] UNLK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLK_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  UNLK_DATA_A = 8'hAA;
  localparam logic [7:0]  UNLK_DATA_B = 8'h55;
  localparam logic [7:0]  CMD_PROG    = 8'hA0;
  localparam logic [7:0]  CMD_ERSETUP = 8'h80;
  localparam logic [7:0]  CMD_CHIP    = 8'h10;
  localparam logic [7:0]  CMD_SECT    = 8'h30;
  localparam logic [7:0]  CMD_RESET   = 8'hF0;

endpackage

// File: rtl/flash_bus_cycler.sv
module flash_bus_cycler #(
  parameter int AW      = 19,
  parameter int T_SETUP = 2,
  parameter int T_PULSE = 3,
  parameter int T_HOLD  = 2,
  parameter int T_READ  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          rd,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          ack,
  output logic [7:0]    rdata,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dout,
  output logic          fl_doe,
  input  logic [7:0]    fl_din,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);

  localparam int TMAX1 = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
  localparam int TMAX2 = (T_HOLD > T_READ) ? T_HOLD : T_READ;
  localparam int TMAX  = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
  localparam int CW    = $clog2(TMAX + 1);

  typedef enum logic [2:0] {
    C_IDLE, C_SETUP, C_PULSE, C_HOLD, C_READ, C_REC
  } cyc_e;

  cyc_e          state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= C_IDLE;
      cnt     <= '0;
      ack     <= 1'b0;
      rdata   <= '0;
      fl_addr <= '0;
      fl_dout <= '0;
      fl_doe  <= 1'b0;
      fl_ce_n <= 1'b1;
      fl_we_n <= 1'b1;
      fl_oe_n <= 1'b1;
    end else begin
      ack <= 1'b0;
      case (state)
        C_IDLE: begin
          if (start) begin
            fl_addr <= addr_i;
            fl_dout <= data_i;
            fl_ce_n <= 1'b0;
            cnt     <= '0;
            if (rd) begin
              fl_oe_n <= 1'b0;
              state   <= C_READ;
            end else begin
              fl_doe <= 1'b1;
              state  <= C_SETUP;
            end
          end
        end
        C_SETUP: begin
          if (cnt == CW'(T_SETUP - 1)) begin
            cnt     <= '0;
            fl_we_n <= 1'b0;
            state   <= C_PULSE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        C_PULSE: begin
          if (cnt == CW'(T_PULSE - 1)) begin
            cnt     <= '0;
            fl_we_n <= 1'b1;
            state   <= C_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        C_HOLD: begin
          if (cnt == CW'(T_HOLD - 1)) begin
            cnt     <= '0;
            fl_ce_n <= 1'b1;
            fl_doe  <= 1'b0;
            state   <= C_REC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        C_READ: begin
          if (cnt == CW'(T_READ - 1)) begin
            cnt     <= '0;
            rdata   <= fl_din;
            fl_oe_n <= 1'b1;
            fl_ce_n <= 1'b1;
            state   <= C_REC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          ack   <= 1'b1;
          state <= C_IDLE;
        end
      endcase
    end
  end

  // Independent low-time counter for write enable
  logic [7:0] we_lo_cnt;
  always_ff @(posedge clk) begin
    if (rst)           we_lo_cnt <= '0;
    else if (!fl_we_n) we_lo_cnt <= we_lo_cnt + 1'b1;
    else               we_lo_cnt <= '0;
  end

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> (we_lo_cnt == 8'(T_PULSE)));

  assert_no_rw_overlap_R5: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_oe_n));

  assert_bus_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (!fl_ce_n && $past(!fl_ce_n)) |-> ($stable(fl_addr) && $stable(fl_dout)));

  assert_we_inside_ce_R5: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> !fl_ce_n);

  assert_read_data_known_R6: assert property (@(posedge clk) disable iff (rst)
    (state == C_READ && cnt == CW'(T_READ - 1)) |-> !$isunknown(fl_din));

endmodule

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
  import flash_ctl_pkg::*;
#(
  parameter int AW      = 19,
  parameter int SW      = 3,
  parameter int SEC_LSB = 16
) (
  input  op_e           op,
  input  logic [2:0]    step,
  input  logic [AW-1:0] tgt_addr,
  input  logic [7:0]    tgt_data,
  input  logic [SW-1:0] sec,
  output logic [AW-1:0] cmd_addr,
  output logic [7:0]    cmd_data
);

  localparam logic [AW-1:0] ADDR_A = AW'(UNLK_ADDR_A);
  localparam logic [AW-1:0] ADDR_B = AW'(UNLK_ADDR_B);

  logic [AW-1:0] sec_base;
  assign sec_base = AW'(sec) << SEC_LSB;

  always_comb begin
    case (step)
      3'd0: begin cmd_addr = ADDR_A; cmd_data = UNLK_DATA_A; end
      3'd1: begin cmd_addr = ADDR_B; cmd_data = UNLK_DATA_B; end
      3'd2: begin
        cmd_addr = ADDR_A;
        cmd_data = (op == OP_PROG) ? CMD_PROG : CMD_ERSETUP;
      end
      3'd3: begin
        if (op == OP_PROG) begin
          cmd_addr = tgt_addr;
          cmd_data = tgt_data;
        end else begin
          cmd_addr = ADDR_A;
          cmd_data = UNLK_DATA_A;
        end
      end
      3'd4: begin cmd_addr = ADDR_B; cmd_data = UNLK_DATA_B; end
      default: begin
        if (op == OP_CHIP) begin
          cmd_addr = ADDR_A;
          cmd_data = CMD_CHIP;
        end else begin
          cmd_addr = sec_base;
          cmd_data = CMD_SECT;
        end
      end
    endcase
  end

endmodule

// File: rtl/flash_poll_eval.sv
module flash_poll_eval
  import flash_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     rd_valid,
  input  logic [7:0] status,
  input  logic     exp7,
  input  logic     late_seen,
  output verdict_e verdict
);

  // A bit 7 match wins over the time-limit flag in the same byte
  always_comb begin
    if (status[7] == exp7)  verdict = V_PASS;
    else if (late_seen)     verdict = V_FAIL;
    else if (status[5])     verdict = V_LATE;
    else                    verdict = V_RETRY;
  end

  assert_status_known_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !$isunknown(status));

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_ctl_pkg::*;
#(
  parameter int AW      = 19,
  parameter int NSEC    = 8,
  parameter int T_SETUP = 2,
  parameter int T_PULSE = 3,
  parameter int T_HOLD  = 2,
  parameter int T_READ  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [7:0]      req_data,
  input  logic [NSEC-1:0] req_sec_mask,
  output logic            idle,
  output logic            done,
  output logic            pass,
  output logic [AW-1:0]   fl_addr,
  output logic [7:0]      fl_dout,
  output logic            fl_doe,
  input  logic [7:0]      fl_din,
  output logic            fl_ce_n,
  output logic            fl_we_n,
  output logic            fl_oe_n
);

  localparam int SW      = (NSEC > 1) ? $clog2(NSEC) : 1;
  localparam int SEC_LSB = AW - SW;

  typedef enum logic [2:0] {
    S_IDLE, S_WISSUE, S_WWAIT, S_RISSUE, S_RWAIT, S_XISSUE, S_XWAIT, S_FIN
  } st_e;

  function automatic logic [SW-1:0] low_idx(input logic [NSEC-1:0] m);
    logic [SW-1:0] r;
    r = '0;
    for (int i = NSEC - 1; i >= 0; i--) begin
      if (m[i]) r = SW'(i);
    end
    return r;
  endfunction

  st_e             state;
  op_e             op_q;
  logic [AW-1:0]   addr_q, poll_addr;
  logic [7:0]      data_q;
  logic [NSEC-1:0] rem_mask;
  logic [2:0]      step;
  logic            exp7, late_seen, done_r, pass_r;

  logic [SW-1:0]   cur_sec;
  logic [2:0]      last_step;
  logic            more_secs;
  logic [AW-1:0]   cmd_addr;
  logic [7:0]      cmd_data;
  logic            cyc_start, cyc_rd, cyc_ack;
  logic [AW-1:0]   cyc_addr;
  logic [7:0]      cyc_data, cyc_rdata;
  verdict_e        verdict;

  assign cur_sec   = low_idx(rem_mask);
  assign last_step = (op_q == OP_PROG) ? 3'd3 : 3'd5;
  assign more_secs = |(rem_mask & (rem_mask - 1'b1));

  flash_cmd_rom #(.AW(AW), .SW(SW), .SEC_LSB(SEC_LSB)) u_rom (
    .op(op_q), .step(step), .tgt_addr(addr_q), .tgt_data(data_q),
    .sec(cur_sec), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  always_comb begin
    cyc_start = (state == S_WISSUE) || (state == S_RISSUE) || (state == S_XISSUE);
    cyc_rd    = (state == S_RISSUE);
    cyc_addr  = cmd_addr;
    cyc_data  = cmd_data;
    if (state == S_RISSUE) begin
      cyc_addr = poll_addr;
    end else if (state == S_XISSUE) begin
      cyc_addr = '0;
      cyc_data = CMD_RESET;
    end
  end

  flash_bus_cycler #(
    .AW(AW), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD), .T_READ(T_READ)
  ) u_cyc (
    .clk(clk), .rst(rst), .start(cyc_start), .rd(cyc_rd),
    .addr_i(cyc_addr), .data_i(cyc_data), .ack(cyc_ack), .rdata(cyc_rdata),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_doe(fl_doe), .fl_din(fl_din),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  flash_poll_eval u_eval (
    .clk(clk), .rst(rst), .rd_valid(cyc_ack && state == S_RWAIT),
    .status(cyc_rdata), .exp7(exp7), .late_seen(late_seen), .verdict(verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_q      <= OP_PROG;
      addr_q    <= '0;
      data_q    <= '0;
      poll_addr <= '0;
      rem_mask  <= '0;
      step      <= '0;
      exp7      <= 1'b0;
      late_seen <= 1'b0;
      done_r    <= 1'b0;
      pass_r    <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            op_q      <= op_e'(req_op);
            addr_q    <= req_addr;
            data_q    <= req_data;
            rem_mask  <= req_sec_mask;
            step      <= '0;
            late_seen <= 1'b0;
            case (op_e'(req_op))
              OP_PROG: begin
                poll_addr <= req_addr;
                exp7      <= req_data[7];
                state     <= S_WISSUE;
              end
              OP_CHIP: begin
                poll_addr <= '0;
                exp7      <= 1'b1;
                state     <= S_WISSUE;
              end
              OP_SECT: begin
                poll_addr <= AW'(low_idx(req_sec_mask)) << SEC_LSB;
                exp7      <= 1'b1;
                if (req_sec_mask == '0) begin
                  pass_r <= 1'b0;
                  state  <= S_FIN;
                end else begin
                  state <= S_WISSUE;
                end
              end
              default: begin
                pass_r <= 1'b0;
                state  <= S_FIN;
              end
            endcase
          end
        end
        S_WISSUE: state <= S_WWAIT;
        S_WWAIT: begin
          if (cyc_ack) begin
            if (step != last_step) begin
              step  <= step + 1'b1;
              state <= S_WISSUE;
            end else if (op_q == OP_SECT && more_secs) begin
              rem_mask <= rem_mask & (rem_mask - 1'b1);
              state    <= S_WISSUE;
            end else begin
              state <= S_RISSUE;
            end
          end
        end
        S_RISSUE: state <= S_RWAIT;
        S_RWAIT: begin
          if (cyc_ack) begin
            case (verdict)
              V_PASS: begin pass_r <= 1'b1; state <= S_FIN; end
              V_LATE: begin late_seen <= 1'b1; state <= S_RISSUE; end
              V_FAIL: state <= S_XISSUE;
              default: state <= S_RISSUE;
            endcase
          end
        end
        S_XISSUE: state <= S_XWAIT;
        S_XWAIT: begin
          if (cyc_ack) begin
            pass_r <= 1'b0;
            state  <= S_FIN;
          end
        end
        default: begin
          done_r <= 1'b1;
          state  <= S_IDLE;
        end
      endcase
    end
  end

  assign idle = (state == S_IDLE);
  assign done = done_r;
  assign pass = pass_r;

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_idle_bus_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    idle |-> (fl_ce_n && fl_we_n && fl_oe_n));

  assert_busy_no_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (!idle && !done && $past(!idle)) |-> $stable(op_q));

endmodule

// File: tb/sim_flash_prog_ctrl.sv
module sim_flash_prog_ctrl;

  localparam int AW = 19;
  localparam int NS = 8;
  localparam int TP = 3;

  typedef struct packed {
    logic [1:0]  op;
    logic [18:0] addr;
    logic [7:0]  data;
    logic [7:0]  mask;
    logic [3:0]  bp;
    logic [1:0]  mode;
    logic        ok;
  } vec_t;

  // mode: 0 normal, 1 bit5 then match, 2 bit5 then no match, 3 bit5 and match together
  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{2'd0, 19'h12345, 8'h3C, 8'h00, 4'd2, 2'd0, 1'b1},
    '{2'd0, 19'h7FFFF, 8'hC1, 8'h00, 4'd0, 2'd0, 1'b1},
    '{2'd1, 19'h00000, 8'h00, 8'h00, 4'd3, 2'd0, 1'b1},
    '{2'd2, 19'h00000, 8'h00, 8'h01, 4'd1, 2'd0, 1'b1},
    '{2'd2, 19'h00000, 8'h00, 8'hA4, 4'd2, 2'd0, 1'b1},
    '{2'd0, 19'h00010, 8'h80, 8'h00, 4'd1, 2'd1, 1'b1},
    '{2'd0, 19'h40000, 8'h00, 8'h00, 4'd2, 2'd2, 1'b0},
    '{2'd2, 19'h00000, 8'h00, 8'h10, 4'd1, 2'd2, 1'b0},
    '{2'd0, 19'h2AAAA, 8'h55, 8'h00, 4'd1, 2'd3, 1'b1},
    '{2'd1, 19'h00000, 8'h00, 8'h00, 4'd0, 2'd1, 1'b1}
  };

  logic clk, rst;
  logic req_valid;
  logic [1:0] req_op;
  logic [AW-1:0] req_addr;
  logic [7:0] req_data;
  logic [NS-1:0] req_sec_mask;
  logic idle, done, pass;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_dout, fl_din;
  logic fl_doe, fl_ce_n, fl_we_n, fl_oe_n;

  flash_prog_ctrl #(.AW(AW), .NSEC(NS), .T_SETUP(2), .T_PULSE(TP), .T_HOLD(2), .T_READ(3)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .req_sec_mask(req_sec_mask), .idle(idle), .done(done), .pass(pass),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_doe(fl_doe), .fl_din(fl_din),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- flash model ----------------
  int wr_n = 0, rd_n = 0, rd_base = 0;
  int bad_hold = 0, bad_width = 0, bad_rdaddr = 0;
  logic [18:0] wlog_a [0:63];
  logic [7:0]  wlog_d [0:63];
  logic prev_we = 1'b1, prev_oe = 1'b1;
  logic [18:0] lat_a = '0;
  int lo_cnt = 0;
  int m_mode = 0, m_bp = 0, mk;
  logic [18:0] m_paddr = '0;
  logic [7:0]  m_exp = '0;

  always @(negedge clk) begin
    if (!fl_we_n) begin
      if (prev_we) begin lat_a = fl_addr; lo_cnt = 1; end
      else lo_cnt++;
    end
    if (fl_we_n && !prev_we) begin
      if (wr_n < 64) begin wlog_a[wr_n] = lat_a; wlog_d[wr_n] = fl_dout; end
      wr_n++;
      if (lo_cnt != TP || fl_ce_n || !fl_doe) bad_width++;
      if (fl_addr != lat_a) bad_hold++;
    end
    if (!fl_oe_n && !fl_ce_n && fl_addr != m_paddr) bad_rdaddr++;
    if (fl_oe_n && !prev_oe) rd_n++;
    prev_we = fl_we_n;
    prev_oe = fl_oe_n;
  end

  always_comb begin
    mk = rd_n - rd_base;
    if (m_mode == 3 && mk >= m_bp)
      fl_din = m_exp | 8'h20;
    else if ((m_mode == 0 && mk >= m_bp) || (m_mode == 1 && mk > m_bp))
      fl_din = m_exp;
    else
      fl_din = {~m_exp[7], 1'b0, (m_mode != 0 && mk >= m_bp), 5'b0};
  end

  // ---------------- checking ----------------
  int nchk = 0, nbad = 0;
  int wb = 0, rb = 0, bhb = 0, bwb = 0, brb = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [26:0] exp_wr(input vec_t v, input int i);
    logic [26:0] r;
    int c;
    r = '0;
    case (i)
      0: r = {19'h05555, 8'hAA};
      1: r = {19'h02AAA, 8'h55};
      2: r = {19'h05555, (v.op == 2'd0) ? 8'hA0 : 8'h80};
      3: r = (v.op == 2'd0) ? {v.addr, v.data} : {19'h05555, 8'hAA};
      4: r = {19'h02AAA, 8'h55};
      default: begin
        if (v.op == 2'd1) r = {19'h05555, 8'h10};
        else begin
          c = 0;
          for (int s = 0; s < NS; s++) begin
            if (v.mask[s]) begin
              if (c == i - 5) r = {19'(s) << 16, 8'h30};
              c++;
            end
          end
        end
      end
    endcase
    return r;
  endfunction

  function automatic logic [18:0] exp_paddr(input vec_t v);
    logic [18:0] a;
    a = '0;
    if (v.op == 2'd0) a = v.addr;
    else if (v.op == 2'd2) begin
      for (int s = NS - 1; s >= 0; s--) if (v.mask[s]) a = 19'(s) << 16;
    end
    return a;
  endfunction

  task automatic start_op(input vec_t v);
    m_mode  = v.mode;
    m_bp    = v.bp;
    m_paddr = exp_paddr(v);
    m_exp   = (v.op == 2'd0) ? v.data : 8'hFF;
    rd_base = rd_n;
    wb = wr_n; rb = rd_n; bhb = bad_hold; bwb = bad_width; brb = bad_rdaddr;
    @(negedge clk);
    req_op = v.op; req_addr = v.addr; req_data = v.data; req_sec_mask = v.mask;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(t < 5000, "R9 done timeout", t, 0);
  endtask

  task automatic finish_op(input vec_t v);
    int ew, er;
    string tg;
    logic [26:0] e;
    wait_done();
    chk(pass == v.ok, (v.mode == 1 || v.mode == 2) ? "R8 result" : "R7 result", pass, v.ok);
    tg = (v.op == 2'd0) ? "R2" : (v.op == 2'd1) ? "R3" : "R4";
    ew = (v.op == 2'd0) ? 4 : (v.op == 2'd1) ? 6 : 5 + $countones(v.mask);
    chk(wr_n - wb == ew + (v.ok ? 0 : 1), {tg, " write count"}, wr_n - wb, ew + (v.ok ? 0 : 1));
    for (int i = 0; i < ew; i++) begin
      e = exp_wr(v, i);
      chk({wlog_a[wb + i], wlog_d[wb + i]} == e, {tg, " write content"},
          {wlog_a[wb + i], wlog_d[wb + i]}, e);
    end
    if (!v.ok)
      chk({wlog_a[wb + ew], wlog_d[wb + ew]} == {19'h0, 8'hF0}, "R8 reset write",
          {wlog_a[wb + ew], wlog_d[wb + ew]}, {19'h0, 8'hF0});
    er = (v.mode == 0 || v.mode == 3) ? v.bp + 1 : v.bp + 2;
    chk(rd_n - rb == er, "R6 poll read count", rd_n - rb, er);
    chk(bad_rdaddr == brb, "R6 poll address", bad_rdaddr - brb, 0);
    chk(bad_width == bwb, "R5 pulse width", bad_width - bwb, 0);
    chk(bad_hold == bhb, "R5 address hold", bad_hold - bhb, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done pulse width", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nchk, 0);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    vec_t vx;
    rst = 1'b1; req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0; req_sec_mask = '0;
    repeat (5) @(negedge clk);
    chk({fl_ce_n, fl_we_n, fl_oe_n} == 3'b111, "R1 strobes in reset", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(idle == 1'b1, "R1 idle after reset", idle, 1);
    chk({fl_ce_n, fl_we_n, fl_oe_n} == 3'b111, "R1 strobes after reset", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);

    for (int i = 0; i < NV; i++) begin
      start_op(VT[i]);
      finish_op(VT[i]);
    end

    // R10: rejected operation code and empty sector mask
    vx = '{2'd3, 19'h01234, 8'h11, 8'h00, 4'd0, 2'd0, 1'b0};
    start_op(vx);
    wait_done();
    chk(pass == 1'b0, "R10 op3 result", pass, 0);
    chk(wr_n == wb && rd_n == rb, "R10 op3 no bus", (wr_n - wb) + (rd_n - rb), 0);
    vx = '{2'd2, 19'h00000, 8'h00, 8'h00, 4'd0, 2'd0, 1'b0};
    start_op(vx);
    wait_done();
    chk(pass == 1'b0, "R10 empty mask result", pass, 0);
    chk(wr_n == wb && rd_n == rb, "R10 empty mask no bus", (wr_n - wb) + (rd_n - rb), 0);

    // R9: a request strobed while busy is ignored
    vx = '{2'd0, 19'h33333, 8'h9E, 8'h00, 4'd4, 2'd0, 1'b1};
    start_op(vx);
    repeat (3) @(negedge clk);
    chk(idle == 1'b0, "R9 busy flag", idle, 0);
    req_op = 2'd1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    finish_op(vx);
    repeat (40) @(negedge clk);
    chk(wr_n - wb == 4, "R9 no stray operation", wr_n - wb, 4);
    chk(idle == 1'b1, "R9 idle after run", idle, 1);

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule